// File: doc/BRIEF.md
# Tiny Accumulator Processor Core

This block is a minimal 8-bit accumulator machine. Its memory is sixteen bytes, and that one memory holds both the program and its data. Registers, memory and the arithmetic unit exchange values over one internal 8-bit bus, which is a multiplexer and not a tri-state line. A step counter walks every instruction through five microsteps. The first two fetch the instruction and the last three execute it. A decoder turns the opcode and the current step into single-bit control strobes.

The memory has no initial contents. A surrounding system writes the program through the preload port, normally while reset is held. It then releases reset and watches the output port. Each OUT instruction produces one value with a one-cycle valid strobe. The halted flag shows that a HALT instruction has stopped the machine.

Top module: `acc_cpu`

## Requirements
- R1: An instruction byte holds the opcode in bits 7:4 and the operand in bits 3:0. The opcodes are NOP 0000, LDA 0001, ADD 0010, SUB 0011, STA 0100, LDI 0101, JMP 0110, JC 0111, JZ 1000, OUT 1110 and HALT 1111. Every instruction takes exactly five clock edges. Counting from the first rising edge with reset released as edge 0, instruction i occupies edges 5i to 5i+4. An OUT or HALT in instruction i takes effect at edge 5i+2.
- R2: LDA n loads A from memory address n. ADD n adds the byte at address n to A. With LDA 14, ADD 15, OUT, HALT at addresses 0 to 3, the value 56 at address 14 and the value 28 at address 15, the core outputs 84 and then halts.
- R3: SUB n computes A plus the inverted byte plus one. Only ADD and SUB update the flags. Carry becomes the carry out of bit 7, and zero is set when the 8-bit result is 0.
- R4: JMP n always moves the program counter to n. JC n moves it only when carry is set, and JZ n moves it only when zero is set. Otherwise execution falls through to the next address.
- R5: LDI n places the 4-bit operand, zero-extended, in A. STA n writes A to memory address n.
- R6: Opcodes 1001 to 1101 change no register, no flag and no memory byte, whatever their operand.
- R7: out_valid is high for exactly one clock per executed OUT. out_value changes only on that clock and then holds.
- R8: After HALT, halted stays high until reset. No further output appears and no register changes.
- R9: Synchronous active-low reset clears the program counter, A, B, the flags, out_value, out_valid and halted. Memory keeps its contents. A preload write stores load_data at load_addr on any clock edge where load_en is high.
- R10: The program counter wraps from 15 to 0 after the fetch at address 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Preload write enable |
| load_addr | input | 4 | Preload write address |
| load_data | input | 8 | Preload write data |
| out_value | output | 8 | Value from the most recent OUT |
| out_valid | output | 1 | One-cycle strobe for a new out_value |
| halted | output | 1 | High from HALT until reset |

## Verification
Every instruction has a fixed length, so a wrong step count, a missed PC increment or a bad wrap shifts the edge of the first OUT and of the halt. This is visible at the ports within the next instruction. A wrong carry or zero flag cannot be seen on the output directly. Each branch test therefore places a different OUT value, at a different edge, on the taken path and on the fall-through path, so a flag error appears within two instructions. A memory write that went to the wrong place or was dropped, or an unused opcode that acted, shows up as a wrong sum at the next OUT.

// File: rtl/acc_cpu_pkg.sv
// Package: acc_cpu_pkg
// Shared opcode, microstep, bus-source and control-word types for the
// accumulator core. Assumes an 8-bit instruction with a 4-bit opcode.
package acc_cpu_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'b0000,
        OP_LDA  = 4'b0001,
        OP_ADD  = 4'b0010,
        OP_SUB  = 4'b0011,
        OP_STA  = 4'b0100,
        OP_LDI  = 4'b0101,
        OP_JMP  = 4'b0110,
        OP_JC   = 4'b0111,
        OP_JZ   = 4'b1000,
        OP_OUT  = 4'b1110,
        OP_HALT = 4'b1111
    } opcode_e;

    // Microsteps: two fetch steps, then three execute steps
    typedef enum logic [2:0] {
        ST_ADDR  = 3'd0,
        ST_FETCH = 3'd1,
        ST_EX1   = 3'd2,
        ST_EX2   = 3'd3,
        ST_EX3   = 3'd4
    } step_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_PC,
        SRC_RAM,
        SRC_IR,
        SRC_A,
        SRC_ALU
    } bus_src_e;

    typedef struct packed {
        bus_src_e bus_src;
        logic     mar_ld;
        logic     ir_ld;
        logic     pc_inc;
        logic     pc_ld;
        logic     a_ld;
        logic     b_ld;
        logic     ram_we;
        logic     out_ld;
        logic     flags_ld;
        logic     alu_sub;
        logic     halt;
    } ctrl_t;

endpackage

// File: rtl/acc_cpu_ram.sv
// Module: acc_cpu_ram
// Unified program/data store. Reads are combinational from raddr and
// writes are synchronous. Assumes the caller muxes the single write port.
// Not reset: contents survive reset.
module acc_cpu_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write one word on a clock edge when enabled
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read from the address register
    assign rdata = mem[raddr];

endmodule

// File: rtl/acc_cpu_alu.sv
// Module: acc_cpu_alu
// Adder/subtractor. Subtraction is a + ~b + 1. Produces the carry out of
// the top bit and a zero indication of the truncated result.
module acc_cpu_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] result,
    output logic              carry,
    output logic              zero
);
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum;

    // Select the second operand and form the widened sum
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    end

    assign result = sum[DATA_W-1:0];
    assign carry  = sum[DATA_W];
    assign zero   = (sum[DATA_W-1:0] == '0);

endmodule

// File: rtl/acc_cpu_ctrl.sv
// Module: acc_cpu_ctrl
// Step counter, halt latch and microcode decoder. Every instruction runs
// all five steps. Once halted, the counter freezes and all strobes are
// suppressed. Assumes the flags are already registered when a conditional
// jump is decoded.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_e opcode,
    input  logic    carry,
    input  logic    zero,
    output step_e   step,
    output ctrl_t   ctrl,
    output logic    halted
);
    step_e step_q;
    logic  halted_q;

    // Advance the microstep counter, wrapping after the last execute step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_ADDR;
        end else if (!halted_q) begin
            step_q <= (step_q == ST_EX3) ? ST_ADDR : step_e'(step_q + 3'd1);
        end
    end

    // Latch the halted state until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= 1'b0;
        end else if (ctrl.halt) begin
            halted_q <= 1'b1;
        end
    end

    // Decode opcode and step into one-hot control strobes
    always_comb begin
        ctrl         = '0;
        ctrl.bus_src = SRC_NONE;
        if (!halted_q) begin
            unique case (step_q)
                ST_ADDR: begin
                    ctrl.bus_src = SRC_PC;
                    ctrl.mar_ld  = 1'b1;
                end
                ST_FETCH: begin
                    ctrl.bus_src = SRC_RAM;
                    ctrl.ir_ld   = 1'b1;
                    ctrl.pc_inc  = 1'b1;
                end
                ST_EX1: begin
                    case (opcode)
                        OP_LDA, OP_ADD, OP_SUB, OP_STA: begin
                            ctrl.bus_src = SRC_IR;
                            ctrl.mar_ld  = 1'b1;
                        end
                        OP_LDI: begin
                            ctrl.bus_src = SRC_IR;
                            ctrl.a_ld    = 1'b1;
                        end
                        OP_JMP: begin
                            ctrl.bus_src = SRC_IR;
                            ctrl.pc_ld   = 1'b1;
                        end
                        OP_JC: begin
                            ctrl.bus_src = SRC_IR;
                            ctrl.pc_ld   = carry;
                        end
                        OP_JZ: begin
                            ctrl.bus_src = SRC_IR;
                            ctrl.pc_ld   = zero;
                        end
                        OP_OUT: begin
                            ctrl.bus_src = SRC_A;
                            ctrl.out_ld  = 1'b1;
                        end
                        OP_HALT: ctrl.halt = 1'b1;
                        default: ;
                    endcase
                end
                ST_EX2: begin
                    case (opcode)
                        OP_LDA: begin
                            ctrl.bus_src = SRC_RAM;
                            ctrl.a_ld    = 1'b1;
                        end
                        OP_ADD, OP_SUB: begin
                            ctrl.bus_src = SRC_RAM;
                            ctrl.b_ld    = 1'b1;
                        end
                        OP_STA: begin
                            ctrl.bus_src = SRC_A;
                            ctrl.ram_we  = 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_EX3: begin
                    if (opcode == OP_ADD || opcode == OP_SUB) begin
                        ctrl.bus_src  = SRC_ALU;
                        ctrl.a_ld     = 1'b1;
                        ctrl.flags_ld = 1'b1;
                        ctrl.alu_sub  = (opcode == OP_SUB);
                    end
                end
                default: ;
            endcase
        end
    end

    assign step   = step_q;
    assign halted = halted_q;

endmodule

// File: rtl/acc_cpu.sv
// Module: acc_cpu (top)
// Accumulator core: registers, the multiplexed internal bus, memory, ALU
// and control. Assumes the program is written through the preload port
// before reset is released. The preload port has priority over a
// store from the core.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] out_value,
    output logic              out_valid,
    output logic              halted
);
    localparam int OPC_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;
    logic [DATA_W-1:0] out_q;
    logic              valid_q;
    logic              carry_q;
    logic              zero_q;

    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] alu_res;
    logic              alu_carry;
    logic              alu_zero;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [DATA_W-1:0] ram_wdata;
    ctrl_t             ctrl;
    step_e             step;
    opcode_e           opcode;

    assign opcode = opcode_e'(ir_q[DATA_W-1 -: OPC_W]);

    acc_cpu_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .carry  (carry_q),
        .zero   (zero_q),
        .step   (step),
        .ctrl   (ctrl),
        .halted (halted)
    );

    // Select the one driver of the internal bus
    always_comb begin
        unique case (ctrl.bus_src)
            SRC_PC:  bus = {{(DATA_W-ADDR_W){1'b0}}, pc_q};
            SRC_RAM: bus = ram_rdata;
            SRC_IR:  bus = {{(DATA_W-ADDR_W){1'b0}}, ir_q[ADDR_W-1:0]};
            SRC_A:   bus = a_q;
            SRC_ALU: bus = alu_res;
            default: bus = '0;
        endcase
    end

    // Merge the preload port and core stores onto the single write port
    always_comb begin
        ram_we    = load_en | ctrl.ram_we;
        ram_waddr = load_en ? load_addr : mar_q;
        ram_wdata = load_en ? load_data : bus;
    end

    acc_cpu_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (mar_q),
        .rdata (ram_rdata)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .a      (a_q),
        .b      (b_q),
        .sub    (ctrl.alu_sub),
        .result (alu_res),
        .carry  (alu_carry),
        .zero   (alu_zero)
    );

    // Program counter: jump load has priority over the fetch increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (ctrl.pc_ld) begin
            pc_q <= bus[ADDR_W-1:0];
        end else if (ctrl.pc_inc) begin
            pc_q <= pc_q + ADDR_W'(1);
        end
    end

    // Address and instruction registers load from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
            ir_q  <= '0;
        end else begin
            if (ctrl.mar_ld) mar_q <= bus[ADDR_W-1:0];
            if (ctrl.ir_ld)  ir_q  <= bus;
        end
    end

    // Accumulator and operand register load from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (ctrl.a_ld) a_q <= bus;
            if (ctrl.b_ld) b_q <= bus;
        end
    end

    // Capture the flags from the ALU on ADD and SUB only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
        end else if (ctrl.flags_ld) begin
            carry_q <= alu_carry;
            zero_q  <= alu_zero;
        end
    end

    // Output register plus a one-clock valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= ctrl.out_ld;
            if (ctrl.out_ld) out_q <= bus;
        end
    end

    assign out_value = out_q;
    assign out_valid = valid_q;

endmodule

// File: rtl/acc_cpu_chk.sv
// Module: acc_cpu_chk
// Property checker bound into acc_cpu. Observes the ports and a few
// internal registers. Drives nothing.
module acc_cpu_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] out_value,
    input logic              out_valid,
    input logic              halted,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] mar,
    input logic [2:0]        step,
    input logic              carry,
    input logic              zero
);
    AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        step <= 3'd4); // R1

    AST_ADDR_FROM_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 3'd0 && !halted) |=> (mar == $past(pc))); // R1

    AST_FETCH_WRAP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 3'd1 && !halted) |=> (pc == $past(pc) + ADDR_W'(1))); // R10

    AST_FLAGS_ON_ALU_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({carry, zero}) |-> ($past(step) == 3'd4)); // R3

    AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R7

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_value) |-> out_valid); // R7

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R8

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc) && !out_valid)); // R8

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_value (out_value),
    .out_valid (out_valid),
    .halted    (halted),
    .pc        (pc_q),
    .mar       (mar_q),
    .step      (step),
    .carry     (carry_q),
    .zero      (zero_q)
);

// File: tb/acc_cpu_bench.sv
// Bench: acc_cpu_bench
// Walks a table of programs with expected output values and edges, then
// runs directed reset and halt checks.
module acc_cpu_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic [7:0] out_value;
    logic       out_valid;
    logic       halted;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .out_value (out_value),
        .out_valid (out_valid),
        .halted    (halted)
    );

    typedef struct packed {
        logic [15:0][7:0] mem;       // mem[i] is address i
        logic [7:0]       exp_out;
        logic [7:0]       out_edge;
        logic [7:0]       halt_edge;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        // 0: LDA 14, ADD 15, OUT, HALT; 56 + 28
        '{mem: 128'h1C38_0000_0000_0000_0000_0000_F0E0_2F1E,
          exp_out: 8'd84, out_edge: 8'd12, halt_edge: 8'd17},
        // 1: LDI 5, SUB 15 (=5), JZ 5 taken -> OUT 0, HALT
        '{mem: 128'h0500_0000_0000_0000_00F0_E0E0_5985_3F55,
          exp_out: 8'd0, out_edge: 8'd17, halt_edge: 8'd22},
        // 2: LDA 15 (200), ADD 14 (100), JZ not taken, JC 8 taken -> OUT 44
        '{mem: 128'hC864_0000_0000_F0E0_E051_E059_7886_2E1F,
          exp_out: 8'd44, out_edge: 8'd22, halt_edge: 8'd27},
        // 3: LDI 7, STA 13, LDI 0, LDA 13, ADD 13, unused 9F, OUT, HALT
        '{mem: 128'h0000_0000_0000_0000_F0E0_9F2D_1D50_4D57,
          exp_out: 8'd14, out_edge: 8'd32, halt_edge: 8'd37},
        // 4: JC 13 not taken, LDA 12, ADD 12, JMP 14, LDI 6, OUT, wrap, JC 13, HALT
        '{mem: 128'hE056_F0FF_0000_0000_0000_0000_6E2C_1C7D,
          exp_out: 8'd6, out_edge: 8'd27, halt_edge: 8'd37}
    };

    function automatic string vtag(int i);
        case (i)
            0:       return "R2";
            1:       return "R3 R4 SUB/JZ";
            2:       return "R3 R4 ADD carry/JC";
            3:       return "R5 R6 LDI/STA/unused";
            default: return "R4 R10 JMP/wrap";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [15:0][7:0] img);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_addr = 4'(a);
            load_data = img[a];
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // Release reset and run a fixed number of edges, logging events
    task automatic run(input int edges, output int first_out, output int out_edge,
                       output int halt_edge, output int pulses, output int doubles);
        logic prev_valid;
        first_out  = -1;
        out_edge   = -1;
        halt_edge  = -1;
        pulses     = 0;
        doubles    = 0;
        prev_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int e = 0; e < edges; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (out_valid) begin
                pulses++;
                if (prev_valid) doubles++;
                if (first_out < 0) begin
                    first_out = int'(out_value);
                    out_edge  = e;
                end
            end
            if (halted && halt_edge < 0) halt_edge = e;
            prev_valid = out_valid;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as one failure
    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        int fo, oe, he, np, nd;

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            rst_n = 1'b0;
            preload(VECS[v].mem);
            repeat (2) @(negedge clk);
            if (v == 0) begin
                // R9: reset state of the outputs
                chk("R9 reset out_value", int'(out_value), 0);
                chk("R9 reset out_valid", int'(out_valid), 0);
                chk("R9 reset halted", int'(halted), 0);
            end
            run(60, fo, oe, he, np, nd);
            chk({vtag(v), " out value"}, fo, int'(VECS[v].exp_out));
            chk("R1 out edge", oe, int'(VECS[v].out_edge));
            chk("R1 halt edge", he, int'(VECS[v].halt_edge));
            chk("R7 single pulse per OUT", np, 1);
            chk("R7 no back-to-back valid", nd, 0);
            chk("R8 halted held", int'(halted), 1);
            chk("R7 out_value held", int'(out_value), int'(VECS[v].exp_out));
        end

        // R8: halt stays frozen over a long idle stretch
        repeat (40) begin
            @(negedge clk);
            if (out_valid || !halted) begin
                chk("R8 frozen after HALT", int'(out_valid), 0);
            end
        end
        chk("R8 still halted after idle", int'(halted), 1);

        // R9: reset clears halt and output; memory is kept
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset clears halted", int'(halted), 0);
        chk("R9 reset clears out_value", int'(out_value), 0);
        run(60, fo, oe, he, np, nd);
        chk("R9 memory kept across reset", fo, 6);
        chk("R9 rerun out edge", oe, 27);

        // R9: preload without reset, then rerun program 0 on new data
        rst_n = 1'b0;
        preload(VECS[0].mem);
        @(negedge clk);
        load_en   = 1'b1;
        load_addr = 4'd15;
        load_data = 8'd200;
        @(negedge clk);
        load_en = 1'b0;
        run(30, fo, oe, he, np, nd);
        chk("R9 preload overwrite", fo, 0);   // 56 + 200 = 256 -> 0
        chk("R2 halts after OUT", he, 17);

        summary();
        $finish;
    end

endmodule